// File: doc/BRIEF.md
# Carry-Fill Right Shift Unit

This block is a 16-bit execution slice that shifts a destination operand right by a variable count. The vacated upper bit positions take the value of the incoming carry flag, not zeros or copies of the sign bit. The count comes from one of two places, selected by a mode input: a 4-bit immediate field or a 16-bit source operand. Each form has its own way of encoding a full 16-position shift.

A one-cycle `issue` strobe captures the operands. On the next clock edge the unit registers the shifted result together with updated negative, zero, overflow and carry flags, and pulses `done` for one cycle. The register file, opcode decoding and the other ALU operations sit outside the block.

Top module: `cfsr_unit`

## Requirements
- R1: One clock after a cycle with `issue` high, `done` is 1 for exactly one cycle. Without `issue`, `done` is 0 and the result and flag outputs hold their values.
- R2: With `imm_mode`=1 the count n equals `imm_cnt` for values 1..15, and `imm_cnt`=0 gives n=16.
- R3: With `imm_mode`=0 the count n equals `src_op` when `src_op` is at most 15, and n=16 for any `src_op` above 15.
- R4: For 0<n<16, `res` equals `dst_op` shifted right by n with bits 15..16-n all equal to `carry_in`.
- R5: For n=16, `res` is 0xFFFF when `carry_in`=1 and 0x0000 when `carry_in`=0.
- R6: For n>0, `flag_c` equals bit n-1 of `dst_op`. For n=16 this is `dst_op[15]`.
- R7: For n=0, `res` equals `dst_op` and `flag_c` equals `carry_in`.
- R8: `flag_n` equals `res[15]`, and `flag_z` is 1 exactly when `res` is 0x0000.
- R9: `flag_v` is 1 exactly when `res[15]` differs from `dst_op[15]`.
- R10: While `rst_n` is low, `res`, all four flags and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | One-cycle operation strobe |
| imm_mode | input | 1 | 1: count from `imm_cnt`; 0: count from `src_op` |
| dst_op | input | 16 | Value to be shifted |
| src_op | input | 16 | Count source in register mode |
| imm_cnt | input | 4 | Count source in immediate mode |
| carry_in | input | 1 | Carry flag before the operation |
| res | output | 16 | Registered shifted result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Sign-change flag |
| flag_c | output | 1 | New carry flag |
| done | output | 1 | Result valid, one cycle after `issue` |

## Verification
Count saturation and the carry-fill rule act in the same cycle whenever n is 16. The bench provokes this case with `imm_cnt`=0 and with `src_op` values 16, 17, 0x00FF and 0xFFFF, each under both carry values. In that case the whole result must equal the fill pattern while the new carry is the old bit 15, and the bench checks both against arithmetic expectations. The other overlap is the carry-keep rule for n=0 together with sign-change detection: with n=0 the bench expects V to be 0 and C to stay at `carry_in`.

// File: rtl/cfsr_pkg.sv
package cfsr_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned IW  = 4;
  localparam int unsigned CW  = $clog2(DW + 1);

  typedef struct packed {
    logic [DW-1:0] res;
    logic          n;
    logic          z;
    logic          v;
    logic          c;
  } cfsr_out_t;
endpackage

// File: rtl/cfsr_count.sv
module cfsr_count
  import cfsr_pkg::*;
(
  input  logic          imm_mode,
  input  logic [DW-1:0] src_op,
  input  logic [IW-1:0] imm_cnt,
  output logic [CW-1:0] cnt
);
  always_comb begin
    if (imm_mode) begin
      cnt = (imm_cnt == '0) ? CW'(DW) : CW'(imm_cnt);
    end else begin
      cnt = (src_op > DW'(DW - 1)) ? CW'(DW) : CW'(src_op);
    end
  end

  always_comb begin
    assert (cnt <= CW'(DW));
  end
endmodule

// File: rtl/cfsr_shift.sv
module cfsr_shift
  import cfsr_pkg::*;
(
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cnt,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  logic [2*DW-1:0] ext;
  logic [2*DW-1:0] shifted;

  always_comb begin
    ext     = {{DW{cin}}, din};
    shifted = ext >> cnt;
    dout    = shifted[DW-1:0];
  end

  always_comb begin
    cout = cin;
    for (int i = 0; i < DW; i++) begin
      if (cnt == CW'(i + 1)) cout = din[i];
    end
  end
endmodule

// File: rtl/cfsr_unit.sv
module cfsr_unit
  import cfsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic        imm_mode,
  input  logic [15:0] dst_op,
  input  logic [15:0] src_op,
  input  logic [3:0]  imm_cnt,
  input  logic        carry_in,
  output logic [15:0] res,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c,
  output logic        done
);
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh_res;
  logic          sh_c;
  cfsr_out_t     nxt_q, cur_q;
  logic          done_d, done_q;

  cfsr_count u_count (
    .imm_mode(imm_mode), .src_op(src_op), .imm_cnt(imm_cnt), .cnt(cnt)
  );

  cfsr_shift u_shift (
    .din(dst_op), .cnt(cnt), .cin(carry_in), .dout(sh_res), .cout(sh_c)
  );

  always_comb begin
    nxt_q = cur_q;
    done_d = 1'b0;
    if (issue) begin
      nxt_q.res = sh_res;
      nxt_q.n   = sh_res[DW-1];
      nxt_q.z   = (sh_res == '0);
      nxt_q.v   = sh_res[DW-1] ^ dst_op[DW-1];
      nxt_q.c   = sh_c;
      done_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cur_q  <= nxt_q;
      done_q <= done_d;
    end
  end

  assign res    = cur_q.res;
  assign flag_n = cur_q.n;
  assign flag_z = cur_q.z;
  assign flag_v = cur_q.v;
  assign flag_c = cur_q.c;
  assign done   = done_q;

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> done);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!done && $stable(res) && $stable(flag_c)));
  p_full_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && imm_mode && imm_cnt == 4'd0) |=> (res == {16{$past(carry_in)}}));
  p_full_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !imm_mode && src_op > 16'd15) |=> (flag_c == $past(dst_op[15])));
  p_zero_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !imm_mode && src_op == 16'd0) |=> (res == $past(dst_op) && flag_c == $past(carry_in)));
  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n == res[15] && flag_z == (res == 16'd0)));
  p_sign_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (flag_v == (res[15] ^ $past(dst_op[15]))));
endmodule

// File: tb/cfsr_unit_bench.sv
module cfsr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue, imm_mode, carry_in;
  logic [15:0] dst_op, src_op;
  logic [3:0]  imm_cnt;
  logic [15:0] res;
  logic        flag_n, flag_z, flag_v, flag_c, done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfsr_unit u_cfsr_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .imm_mode(imm_mode),
    .dst_op(dst_op), .src_op(src_op), .imm_cnt(imm_cnt), .carry_in(carry_in),
    .res(res), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent arithmetic model: fill = carry * (2^16 - 2^(16-n))
  task automatic run_op(input logic mode, input logic [15:0] d, input logic [15:0] s,
                        input logic [3:0] im, input logic ci);
    int          n;
    logic [31:0] exp_r;
    logic        exp_c;
    n = mode ? ((im == 0) ? 16 : int'(im)) : ((s > 15) ? 16 : int'(s));
    exp_r = (32'(d) / (32'd1 << n)) + (ci ? (32'h10000 - (32'h10000 >> n)) : 32'd0);
    exp_c = (n == 0) ? ci : d[n-1];
    @(negedge clk);
    issue = 1; imm_mode = mode; dst_op = d; src_op = s; imm_cnt = im; carry_in = ci;
    @(negedge clk);
    issue = 0;
    chk("R1 done", 32'(done), 1);
    if (n == 0) chk("R7 res", 32'(res), exp_r);
    else if (n == 16) chk("R5 res", 32'(res), exp_r);
    else chk(mode ? "R2/R4 res" : "R3/R4 res", 32'(res), exp_r);
    chk(n == 0 ? "R7 c" : "R6 c", 32'(flag_c), 32'(exp_c));
    chk("R8 n", 32'(flag_n), 32'(exp_r[15]));
    chk("R8 z", 32'(flag_z), 32'(exp_r[15:0] == 0));
    chk("R9 v", 32'(flag_v), 32'(exp_r[15] ^ d[15]));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] pats[6];
    logic [15:0] big[5];
    pats = '{16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'hA5C3, 16'h1234};
    big  = '{16'd16, 16'd17, 16'h00FF, 16'h8000, 16'hFFFF};
    rst_n = 0; issue = 0; imm_mode = 0; dst_op = 0; src_op = 0; imm_cnt = 0; carry_in = 0;
    repeat (3) @(negedge clk);
    chk("R10 res", 32'(res), 0);
    chk("R10 flags", 32'({flag_n, flag_z, flag_v, flag_c}), 0);
    chk("R10 done", 32'(done), 0);
    rst_n = 1;
    @(negedge clk);
    for (int p = 0; p < 6; p++)
      for (int ci = 0; ci < 2; ci++) begin
        for (int k = 0; k < 16; k++) run_op(1'b1, pats[p], 16'h0, 4'(k), ci[0]);
        for (int k = 0; k < 16; k++) run_op(1'b0, pats[p], 16'(k), 4'h0, ci[0]);
        for (int b = 0; b < 5; b++) run_op(1'b0, pats[p], big[b], 4'h0, ci[0]);
      end
    // R1: hold with no issue
    run_op(1'b1, 16'hA5C3, 16'h0, 4'd3, 1'b1);
    @(negedge clk);
    dst_op = 16'h0; imm_cnt = 4'd0; carry_in = 0;
    @(negedge clk);
    chk("R1 nodone", 32'(done), 0);
    chk("R1 hold res", 32'(res), 32'hF4B8);
    chk("R1 hold c", 32'(flag_c), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule